// File: doc/BRIEF.md
# Shared Bus Ownership Handshake Controller

This block sits on the master side of an external bus whose ownership is decided by an outside arbiter. It drives an active-low request line and samples an active-low grant line on every rising clock edge. From these, and from three signals exchanged with a local transfer engine, it decides each cycle four things. Does the master hold the bus? May a new transfer begin? Are the shared bus outputs driven? If they are driven, must they sit at their inactive levels?

The transfer engine raises `work_pending` while it has work queued. It may pulse `xfer_start` only while `start_permit` is high. It pulses `xfer_done` when a started transfer ends. The controller does not release the bus while a transfer is open.

The arbiter may also leave grant on the master while it is not requesting (parking). A parked master drives idle levels on the shared outputs. When it wants the bus again it re-requests and waits two cycles before it is allowed to start. A grant that disappears makes the controller stop driving in the following cycle. The internal state storage is one-hot or binary, chosen by a parameter, with identical port behaviour.

Top module: `xbus_owner_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `req_n`=1, `bus_drive_en`=0, `bus_idle_lvl`=0 and `start_permit`=0.
- R2: When idle (not requesting, not driving) with grant absent (`gnt_n`=1) and `work_pending`=1 at a clock edge, `req_n` is 0 after that edge.
- R3: While requesting, grant sampled present (`gnt_n`=0) at an edge makes the master owner after that edge: `start_permit`=1, `bus_drive_en`=1, `bus_idle_lvl`=0, `req_n`=0.
- R4: An owner keeps ownership, with all outputs unchanged, across every edge at which grant is present and either `work_pending`=1 or a transfer is open.
- R5: An owner with grant present releases at an edge where `work_pending`=0, no transfer is open and `xfer_start`=0. `req_n` goes to 1 after that edge, and `start_permit` is 0 in that cycle and in the next.
- R6: An owner that samples grant absent stops driving in the next cycle (`bus_drive_en`=0, `start_permit`=0) and keeps `req_n`=0. It becomes owner again one edge after grant is sampled present.
- R7: Grant sampled present at an edge while the master is idle parks it: `req_n`=1, `bus_drive_en`=1, `bus_idle_lvl`=1, `start_permit`=0. An owner that releases with grant present is parked in the same way.
- R8: A parked master that samples `work_pending`=1 drives `req_n`=0 after that edge and keeps idle levels driven. `start_permit` rises exactly two cycles after `req_n` fell, provided grant was present at both edges in between.
- R9: Grant sampled absent while parked leads to the idle state (`bus_drive_en`=0) after the edge. Grant sampled absent during the two wait cycles leads to plain requesting (`req_n`=0, `bus_drive_en`=0).
- R10: A transfer counts as open from the edge that samples `xfer_start`=1 until the edge that samples `xfer_done`=1. An open transfer blocks release even when `work_pending`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| work_pending | input | 1 | Transfer engine has queued work |
| xfer_start | input | 1 | Transfer engine begins a transfer this cycle |
| xfer_done | input | 1 | Open transfer completes this cycle |
| gnt_n | input | 1 | Active-low grant from the external arbiter |
| req_n | output | 1 | Active-low request to the external arbiter |
| start_permit | output | 1 | High only while the master owns the bus |
| bus_drive_en | output | 1 | Shared bus outputs are driven (low means tri-state) |
| bus_idle_lvl | output | 1 | While driven, shared outputs are forced to inactive levels |

## Verification
The embedded properties take for granted that the transfer engine pulses `xfer_start` only while `start_permit` is high. They also assume `xfer_done` arrives only for a transfer that was started. `gnt_n` and `work_pending` are left free to change at any edge. The bench draws grant and pending values at random, including long grant-held and grant-absent runs that reach parking. It raises the start strobe only when its own model says the permit is high and no transfer is open, and it raises done only while its model holds a transfer open.

// File: rtl/xbus_owner_pkg.sv
package xbus_owner_pkg;

  // Logical ownership states; the numeric value doubles as the one-hot bit index.
  typedef enum logic [2:0] {
    XB_IDLE = 3'd0,  // not requesting, shared outputs floating
    XB_REQ  = 3'd1,  // requesting, waiting for grant, outputs floating
    XB_OWN  = 3'd2,  // owner, transfers may start
    XB_PARK = 3'd3,  // grant parked on an idle master, inactive levels driven
    XB_PW1  = 3'd4,  // re-request from park, first wait cycle
    XB_PW2  = 3'd5   // re-request from park, second wait cycle
  } xb_state_e;

  localparam int XB_NUM_STATES = 6;
  localparam int XB_STATE_W    = $clog2(XB_NUM_STATES);

  typedef struct packed {
    logic req_n;
    logic drive_en;
    logic idle_lvl;
    logic permit;
  } xb_outs_t;

  localparam xb_outs_t XB_OUTS_RESET = '{req_n: 1'b1, drive_en: 1'b0, idle_lvl: 1'b0, permit: 1'b0};

endpackage

// File: rtl/xbus_owner_next.sv
module xbus_owner_next
  import xbus_owner_pkg::*;
(
  input  xb_state_e cur_st,
  input  logic      gnt,
  input  logic      pending,
  input  logic      busy,
  input  logic      start,
  output xb_state_e nxt_st
);

  logic may_release;
  assign may_release = !pending && !busy && !start;

  always_comb begin
    nxt_st = cur_st;
    unique case (cur_st)
      XB_IDLE: begin
        if (gnt)          nxt_st = XB_PARK;
        else if (pending) nxt_st = XB_REQ;
      end
      XB_REQ: begin
        if (gnt)                    nxt_st = XB_OWN;
        else if (!pending && !busy) nxt_st = XB_IDLE;
      end
      XB_OWN: begin
        if (!gnt)             nxt_st = XB_REQ;
        else if (may_release) nxt_st = XB_PARK;
      end
      XB_PARK: begin
        if (!gnt)         nxt_st = XB_IDLE;
        else if (pending) nxt_st = XB_PW1;
      end
      XB_PW1:  nxt_st = gnt ? XB_PW2 : XB_REQ;
      XB_PW2:  nxt_st = gnt ? XB_OWN : XB_REQ;
      default: nxt_st = XB_IDLE;
    endcase
  end

endmodule

// File: rtl/xbus_owner_state_reg.sv
module xbus_owner_state_reg
  import xbus_owner_pkg::*;
#(
  parameter bit ONE_HOT = 1'b1
) (
  input  logic      clk,
  input  logic      rst,
  input  xb_state_e nxt_st,
  output xb_state_e cur_st
);

  generate
    if (ONE_HOT) begin : g_onehot
      logic [XB_NUM_STATES-1:0] hot_q;

      always_ff @(posedge clk) begin
        if (rst) hot_q <= XB_NUM_STATES'(1) << XB_IDLE;
        else     hot_q <= XB_NUM_STATES'(1) << nxt_st;
      end

      always_comb begin
        cur_st = XB_IDLE;
        for (int i = 0; i < XB_NUM_STATES; i++) begin
          if (hot_q[i]) cur_st = xb_state_e'(XB_STATE_W'(i));
        end
      end
    end else begin : g_binary
      xb_state_e bin_q;

      always_ff @(posedge clk) begin
        if (rst) bin_q <= XB_IDLE;
        else     bin_q <= nxt_st;
      end

      assign cur_st = bin_q;
    end
  endgenerate

endmodule

// File: rtl/xbus_owner_outreg.sv
module xbus_owner_outreg
  import xbus_owner_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  xb_state_e nxt_st,
  output xb_outs_t  outs_q
);

  xb_outs_t outs_d;

  always_comb begin
    outs_d = XB_OUTS_RESET;
    unique case (nxt_st)
      XB_IDLE: outs_d = XB_OUTS_RESET;
      XB_REQ:  outs_d = '{req_n: 1'b0, drive_en: 1'b0, idle_lvl: 1'b0, permit: 1'b0};
      XB_OWN:  outs_d = '{req_n: 1'b0, drive_en: 1'b1, idle_lvl: 1'b0, permit: 1'b1};
      XB_PARK: outs_d = '{req_n: 1'b1, drive_en: 1'b1, idle_lvl: 1'b1, permit: 1'b0};
      XB_PW1,
      XB_PW2:  outs_d = '{req_n: 1'b0, drive_en: 1'b1, idle_lvl: 1'b1, permit: 1'b0};
      default: outs_d = XB_OUTS_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) outs_q <= XB_OUTS_RESET;
    else     outs_q <= outs_d;
  end

endmodule

// File: rtl/xbus_owner_ctrl.sv
module xbus_owner_ctrl
  import xbus_owner_pkg::*;
#(
  parameter bit ONE_HOT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic work_pending,
  input  logic xfer_start,
  input  logic xfer_done,
  input  logic gnt_n,
  output logic req_n,
  output logic start_permit,
  output logic bus_drive_en,
  output logic bus_idle_lvl
);

  xb_state_e cur_st;
  xb_state_e nxt_st;
  xb_outs_t  outs_q;
  logic      busy_q;

  // R10: open-transfer tracking between start and done strobes
  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= (busy_q | xfer_start) & ~xfer_done;
  end

  xbus_owner_next u_next (
    .cur_st  (cur_st),
    .gnt     (~gnt_n),
    .pending (work_pending),
    .busy    (busy_q),
    .start   (xfer_start),
    .nxt_st  (nxt_st)
  );

  xbus_owner_state_reg #(.ONE_HOT(ONE_HOT)) u_state (
    .clk    (clk),
    .rst    (rst),
    .nxt_st (nxt_st),
    .cur_st (cur_st)
  );

  xbus_owner_outreg u_outs (
    .clk    (clk),
    .rst    (rst),
    .nxt_st (nxt_st),
    .outs_q (outs_q)
  );

  assign req_n        = outs_q.req_n;
  assign start_permit = outs_q.permit;
  assign bus_drive_en = outs_q.drive_en;
  assign bus_idle_lvl = outs_q.idle_lvl;

  // Immediate check of the reset values (R1)
  always_ff @(posedge clk) begin
    if (!rst && $past(rst)) begin
      assert_reset_outs_R1: assert (req_n && !bus_drive_en && !bus_idle_lvl && !start_permit)
        else $error("outputs not at reset values after reset");
    end
  end

  assert_request_from_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (req_n && !bus_drive_en && gnt_n && work_pending) |=> !req_n);

  assert_own_needs_grant_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(start_permit) |-> $past(!gnt_n));

  assert_release_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(req_n) |-> !start_permit ##1 !start_permit);

  assert_grant_loss_float_R6: assert property (@(posedge clk) disable iff (rst)
    (start_permit && gnt_n) |=> (!bus_drive_en && !req_n));

  assert_park_on_grant_R7: assert property (@(posedge clk) disable iff (rst)
    (req_n && !bus_drive_en && !gnt_n) |=> (bus_drive_en && bus_idle_lvl && req_n));

  assert_park_two_cycle_wait_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(start_permit) && $past(bus_idle_lvl)) |->
      ($past(!req_n, 2) && $past(!gnt_n, 1) && $past(!gnt_n, 2)));

  assert_park_grant_removed_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_idle_lvl && req_n && gnt_n) |=> !bus_drive_en);

  assert_start_only_permitted_R10: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> start_permit);

endmodule

// File: tb/xbus_owner_ctrl_tb.sv
module xbus_owner_ctrl_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic work_pending = 1'b0;
  logic xfer_start = 1'b0;
  logic xfer_done = 1'b0;
  logic gnt_n = 1'b1;
  logic req_n, start_permit, bus_drive_en, bus_idle_lvl;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  localparam int M_IDLE = 0, M_REQ = 1, M_OWN = 2, M_PARK = 3, M_PW1 = 4, M_PW2 = 5;
  int    m_st   = M_IDLE;
  bit    m_busy = 1'b0;
  string m_tag  = "R1";

  always #2 clk = ~clk;  // 250 MHz

  xbus_owner_ctrl u_dut (
    .clk          (clk),
    .rst          (rst),
    .work_pending (work_pending),
    .xfer_start   (xfer_start),
    .xfer_done    (xfer_done),
    .gnt_n        (gnt_n),
    .req_n        (req_n),
    .start_permit (start_permit),
    .bus_drive_en (bus_drive_en),
    .bus_idle_lvl (bus_idle_lvl)
  );

  // Expected outputs {req_n, drive_en, idle_lvl, permit} for a model state
  function automatic logic [3:0] exp_outs(input int st);
    case (st)
      M_REQ:         return 4'b0000;
      M_OWN:         return 4'b0101;
      M_PARK:        return 4'b1110;
      M_PW1, M_PW2:  return 4'b0110;
      default:       return 4'b1000;
    endcase
  endfunction

  // Reference model step at a rising edge
  task automatic model_step(input bit p, input bit g, input bit s, input bit d);
    int nx;
    nx = m_st;
    case (m_st)
      M_IDLE: if (g) begin nx = M_PARK; m_tag = "R7"; end
              else if (p) begin nx = M_REQ; m_tag = "R2"; end
              else m_tag = "R2";
      M_REQ:  if (g) begin nx = M_OWN; m_tag = "R3"; end
              else if (!p && !m_busy) begin nx = M_IDLE; m_tag = "R6"; end
              else m_tag = "R6";
      M_OWN:  if (!g) begin nx = M_REQ; m_tag = "R6"; end
              else if (!p && !m_busy && !s) begin nx = M_PARK; m_tag = "R5"; end
              else m_tag = (m_busy || s) ? "R10" : "R4";
      M_PARK: if (!g) begin nx = M_IDLE; m_tag = "R9"; end
              else if (p) begin nx = M_PW1; m_tag = "R8"; end
              else m_tag = "R7";
      M_PW1:  begin nx = g ? M_PW2 : M_REQ; m_tag = g ? "R8" : "R9"; end
      M_PW2:  begin nx = g ? M_OWN : M_REQ; m_tag = g ? "R8" : "R9"; end
      default: nx = M_IDLE;
    endcase
    m_st   = nx;
    m_busy = (m_busy | s) & ~d;
  endtask

  task automatic check_outs(input string tag);
    logic [3:0] act, exp;
    act = {req_n, bus_drive_en, bus_idle_lvl, start_permit};
    exp = exp_outs(m_st);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {req_n,drive_en,idle_lvl,permit} actual=%b expected=%b at %0t",
               tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit p, input bit g, input bit s, input bit d);
    @(negedge clk);
    work_pending = p; gnt_n = ~g; xfer_start = s; xfer_done = d;
    @(posedge clk);
    model_step(p, g, s, d);
    #1 check_outs(m_tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset values, during and just after reset
    repeat (3) @(posedge clk);
    #1 check_outs("R1");
    @(negedge clk) rst = 1'b0;
    @(posedge clk) #1 check_outs("R1");

    // R2/R3: request from idle, then grant
    cyc(1, 0, 0, 0);
    cyc(1, 0, 0, 0);
    cyc(1, 1, 0, 0);
    // R10: transfer open across pending drop blocks release
    cyc(1, 1, 1, 0);
    cyc(0, 1, 0, 0);
    cyc(0, 1, 0, 1);
    // R5: release with grant kept -> parked (R7)
    cyc(0, 1, 0, 0);
    cyc(0, 1, 0, 0);
    // R8: re-request from park, two wait cycles then ownership
    cyc(1, 1, 0, 0);
    cyc(1, 1, 0, 0);
    cyc(1, 1, 0, 0);
    cyc(1, 1, 0, 0);
    // R6: grant loss while owned, then regain
    cyc(1, 0, 0, 0);
    cyc(1, 0, 0, 0);
    cyc(1, 1, 0, 0);
    // R5: release with grant gone -> requesting then idle
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    // R7 then R9: park and grant removal while parked
    cyc(0, 1, 0, 0);
    cyc(0, 0, 0, 0);
    // R9: grant removed during park wait
    cyc(0, 1, 0, 0);
    cyc(1, 1, 0, 0);
    cyc(1, 0, 0, 0);
    cyc(1, 1, 0, 0);

    // Random mix with long grant runs
    begin
      bit g = 1'b0;
      bit p = 1'b0;
      for (int n = 0; n < 4000; n++) begin
        bit s, d;
        if (($urandom % 6) == 0) g = ~g;
        if (($urandom % 5) == 0) p = ~p;
        s = (m_st == M_OWN) && !m_busy && (($urandom % 3) == 0);
        d = m_busy && (($urandom % 3) == 0);
        cyc(p, g, s, d);
      end
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule